// File: doc/BRIEF.md
# Serial Transmit Path with Mu-law / A-law Compression

This block turns words written by a host into a serial bit stream on one data output. The host loads a 16-bit low register and a 16-bit high register. When a frame starts, the word for the current phase is moved from these registers into a 32-bit shift stage and sent most significant bit first, one bit per serial clock tick. Words of 16 bits or fewer come from the low register only. Longer words take their upper bits from the high register.

A frame has one phase or two, and each phase has its own word length code. The second phase reloads the shift stage from the registers, so the host can write new data while the first phase is still being sent. On the load path the low register can optionally be compressed to an 8-bit G.711 code, using either mu-law or A-law. A ready flag tells the host when the registers have been consumed. The serial clock arrives as a one-cycle enable strobe in the system clock domain, and the frame sync is sampled on those strobes.

Top module: `ser_tx_comp`

## Requirements
- R1: After reset `rdy_o` is 1, `sdo_o` is 0, and both data registers hold zero, so a frame sent with no host write carries all zeros.
- R2: A host write (`wr_en_i`=1) stores `wr_data_i` in the high register when `wr_hi_i`=1 and in the low register when `wr_hi_i`=0.
- R3: When the block is idle, a tick (`sclk_en_i`=1) with `fsync_i`=1 loads the shift stage, and the first bit appears on `sdo_o` after that clock edge. Each later tick moves the output to the next bit, most significant bit first. Between ticks `sdo_o` does not change.
- R4: Length codes 0 to 5 select 8, 12, 16, 20, 24 and 32 bits, and codes 6 and 7 also select 32 bits. A word of 16 bits or fewer is made of the low bits of the low register. The low register bits above the word length are not sent.
- R5: A word longer than 16 bits sends the low (L-16) bits of the high register first, then all 16 bits of the low register.
- R6: When `dual_phase_i`=1, the tick after the last bit of phase 1 reloads the shift stage from the current register contents, using the phase-2 length code.
- R7: The tick after the last bit of a frame returns the block to idle with `sdo_o`=0. If `fsync_i`=1 on that same tick, a new frame starts at once.
- R8: `fsync_i` has no effect while a frame is in progress.
- R9: `comp_mode_i`=2'b10 sends a mu-law code and 2'b11 sends an A-law code, both built from the low register. A compressed word is always 8 bits long, whatever the length code. Modes 2'b00 and 2'b01 send the data unchanged.
- R10: The mu-law code is built from sample bits [15:2] taken as a signed 14-bit value. The magnitude is clipped to 8159 and biased by 33. The result is coded as a 3-bit segment and a 4-bit mantissa, and the whole code is inverted. The top code bit is 1 for non-negative samples (0 maps to 8'hFF, full-scale positive to 8'h80, full-scale negative to 8'h00).
- R11: The A-law code is built from sample bits [15:3] taken as a signed 13-bit value. Negative samples use the one's complement magnitude. The code is XORed with 8'hD5 for non-negative samples and with 8'h55 for negative ones (0 maps to 8'hD5).
- R12: `rdy_o` goes to 1 on every load of the shift stage and to 0 on a low-register write. When both happen on the same edge, the write wins. A high-register write leaves `rdy_o` unchanged.
- R13: If the host writes nothing new, the next frame sends the same register contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_hi_i | input | 1 | Write target: 1 = high register, 0 = low register |
| wr_data_i | input | 16 | Host write data |
| comp_mode_i | input | 2 | Compression mode: 0x none, 10 mu-law, 11 A-law |
| dual_phase_i | input | 1 | Frame has two phases |
| ph1_len_i | input | 3 | Word length code for phase 1 |
| ph2_len_i | input | 3 | Word length code for phase 2 |
| sclk_en_i | input | 1 | Serial clock tick strobe |
| fsync_i | input | 1 | Frame sync, sampled on ticks |
| sdo_o | output | 1 | Serial data output |
| rdy_o | output | 1 | Registers consumed, ready for new data |

## Verification
The bench checks the 20-bit and 24-bit lengths, where only part of the high register is sent. A wrong split there would send the wrong high bits or put them after the low half. It writes the low register in the middle of phase 1 and expects phase 2 to carry the new value while phase 1 keeps the old one. A design that loads both phases at frame start, or that clears the ready flag wrongly, fails here. The compression vectors include zero, both full-scale extremes and values near segment edges, so a missing clip, an off-by-one in the negation or a wrong inversion mask gives a different code. Frame syncs are also sent in the middle of a frame and on the last tick of a frame, to catch a design that restarts too early or drops a frame sent back to back.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int REG_W  = 16;
  localparam int WORD_W = 2 * REG_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    CMP_NONE0 = 2'b00,
    CMP_NONE1 = 2'b01,
    CMP_MU    = 2'b10,
    CMP_A     = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PH1  = 2'd1,
    ST_PH2  = 2'd2
  } tx_state_e;

  function automatic logic [CNT_W:0] len_bits(input logic [2:0] code);
    case (code)
      3'd0:    len_bits = (CNT_W+1)'(8);
      3'd1:    len_bits = (CNT_W+1)'(12);
      3'd2:    len_bits = (CNT_W+1)'(16);
      3'd3:    len_bits = (CNT_W+1)'(20);
      3'd4:    len_bits = (CNT_W+1)'(24);
      default: len_bits = (CNT_W+1)'(32);
    endcase
  endfunction
endpackage

// File: rtl/ser_tx_regs.sv
module ser_tx_regs #(
  parameter int W = ser_tx_pkg::REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic [W-1:0] regs_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && (wr_hi_i == 1'(g)))        regs_q[g] <= wr_data_i;
    end
  end

  assign lo_o = regs_q[0];
  assign hi_o = regs_q[1];
endmodule

// File: rtl/ser_tx_compand.sv
module ser_tx_compand (
  input  logic [15:0] sample_i,
  input  logic        a_law_i,
  output logic [7:0]  code_o
);
  logic [13:0] s14, mag_u, bias_u;
  logic        neg_u, ovf_u;
  logic [2:0]  seg_u;
  logic [3:0]  man_u;
  logic [7:0]  code_u;

  // mu-law on a 14-bit sample
  always_comb begin
    s14   = sample_i[15:2];
    neg_u = s14[13];
    mag_u = neg_u ? (~s14 + 14'd1) : s14;
    if (mag_u > 14'd8159) mag_u = 14'd8159;
    bias_u = mag_u + 14'd33;
    ovf_u  = bias_u[13];
    seg_u  = 3'd0;
    for (int b = 6; b <= 12; b++) if (bias_u[b]) seg_u = 3'(b - 5);
    man_u  = 4'(bias_u >> ({1'b0, seg_u} + 4'd1));
    code_u = ovf_u ? 8'h7F : {1'b0, seg_u, man_u};
    code_u = code_u ^ (neg_u ? 8'h7F : 8'hFF);
  end

  logic [12:0] s13, mag_a;
  logic        neg_a;
  logic [2:0]  seg_a;
  logic [3:0]  man_a;
  logic [7:0]  code_a;

  // A-law on a 13-bit sample
  always_comb begin
    s13   = sample_i[15:3];
    neg_a = s13[12];
    mag_a = neg_a ? ~s13 : s13;
    seg_a = 3'd0;
    for (int b = 5; b <= 11; b++) if (mag_a[b]) seg_a = 3'(b - 4);
    man_a  = (seg_a < 3'd2) ? 4'(mag_a >> 1) : 4'(mag_a >> seg_a);
    code_a = {1'b0, seg_a, man_a} ^ (neg_a ? 8'h55 : 8'hD5);
  end

  assign code_o = a_law_i ? code_a : code_u;
endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int SW = ser_tx_pkg::WORD_W,
  parameter int CW = ser_tx_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          fsync_i,
  input  logic          dual_i,
  input  logic [SW-1:0] ld_word_i,
  input  logic [CW:0]   ld_len_i,
  output logic          ph2_sel_o,
  output logic          ld_o,
  output logic          busy_o,
  output logic          sdo_o
);
  tx_state_e     state_q;
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          last, to_ph2, fin, start;

  assign busy_o    = (state_q != ST_IDLE);
  assign last      = (cnt_q == '0);
  assign to_ph2    = tick_i && busy_o && last && (state_q == ST_PH1) && dual_i;
  assign fin       = tick_i && busy_o && last && !to_ph2;
  assign start     = tick_i && fsync_i && (!busy_o || fin);
  assign ld_o      = start || to_ph2;
  assign ph2_sel_o = to_ph2;
  assign sdo_o     = sh_q[SW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (ld_o) begin
      state_q <= to_ph2 ? ST_PH2 : ST_PH1;
      sh_q    <= ld_word_i;
      cnt_q   <= CW'(ld_len_i - 1'b1);
    end else if (fin) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (tick_i && busy_o) begin
      sh_q    <= {sh_q[SW-2:0], 1'b0};
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ser_tx_comp.sv
module ser_tx_comp
  import ser_tx_pkg::*;
#(
  parameter int REG_WIDTH = ser_tx_pkg::REG_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 wr_hi_i,
  input  logic [REG_WIDTH-1:0] wr_data_i,
  input  logic [1:0]           comp_mode_i,
  input  logic                 dual_phase_i,
  input  logic [2:0]           ph1_len_i,
  input  logic [2:0]           ph2_len_i,
  input  logic                 sclk_en_i,
  input  logic                 fsync_i,
  output logic                 sdo_o,
  output logic                 rdy_o
);
  localparam int SW = 2 * REG_WIDTH;
  localparam int CW = $clog2(SW);

  logic [REG_WIDTH-1:0] lo_reg, hi_reg;
  logic [7:0]           cmp_code;
  logic                 ph2_sel, ld_pulse, busy;
  logic [CW:0]          len, ld_len;
  logic [SW-1:0]        lo_just, full_just, ld_word;
  logic                 cmp_on;

  ser_tx_regs #(.W(REG_WIDTH)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_hi_i, .wr_data_i,
    .lo_o(lo_reg), .hi_o(hi_reg)
  );

  ser_tx_compand u_cmp (
    .sample_i(lo_reg[REG_WIDTH-1 -: 16]),
    .a_law_i (comp_mode_i[0]),
    .code_o  (cmp_code)
  );

  // load word: left-justified in the shift stage
  assign cmp_on    = comp_mode_i[1];
  assign len       = len_bits(ph2_sel ? ph2_len_i : ph1_len_i);
  assign lo_just   = {lo_reg, {REG_WIDTH{1'b0}}} << ((CW+1)'(REG_WIDTH) - len);
  assign full_just = {hi_reg, lo_reg} << ((CW+1)'(SW) - len);
  assign ld_word   = cmp_on ? {cmp_code, {(SW-8){1'b0}}}
                            : ((len <= (CW+1)'(REG_WIDTH)) ? lo_just : full_just);
  assign ld_len    = cmp_on ? (CW+1)'(8) : len;

  ser_tx_shifter #(.SW(SW), .CW(CW)) u_shift (
    .clk_i, .rst_ni,
    .tick_i   (sclk_en_i),
    .fsync_i,
    .dual_i   (dual_phase_i),
    .ld_word_i(ld_word),
    .ld_len_i (ld_len),
    .ph2_sel_o(ph2_sel),
    .ld_o     (ld_pulse),
    .busy_o   (busy),
    .sdo_o
  );

  // low write beats a same-edge load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdy_o <= 1'b1;
    else if (wr_en_i && !wr_hi_i)  rdy_o <= 1'b0;
    else if (ld_pulse)             rdy_o <= 1'b1;
  end
endmodule

// File: rtl/ser_tx_comp_chk.sv
module ser_tx_comp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic wr_hi_i,
  input logic sclk_en_i,
  input logic fsync_i,
  input logic sdo_o,
  input logic rdy_o,
  input logic ld_i,
  input logic busy_i
);
  // R12
  rdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> !rdy_o);

  // R12
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !(wr_en_i && !wr_hi_i)) |=> rdy_o);

  // R12
  rdy_hi_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i && !ld_i) |=> $stable(rdy_o));

  // R3
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_i |=> $stable(sdo_o));

  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !(sclk_en_i && fsync_i)) |=> !sdo_o);

  // R3
  load_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> sclk_en_i);
endmodule

bind ser_tx_comp ser_tx_comp_chk u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_hi_i, .sclk_en_i, .fsync_i, .sdo_o, .rdy_o,
  .ld_i  (ld_pulse),
  .busy_i(busy)
);

// File: tb/ser_tx_comp_tb_top.sv
`timescale 1ns/1ps
module ser_tx_comp_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 0, wr_hi = 0, dual = 0, sclk_en = 0, fsync = 0;
  logic [15:0] wr_data = '0;
  logic [1:0]  cmode = 2'b00;
  logic [2:0]  l1 = 3'd2, l2 = 3'd2;
  logic        sdo, rdy;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  ser_tx_comp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .comp_mode_i(cmode), .dual_phase_i(dual),
    .ph1_len_i(l1), .ph2_len_i(l2), .sclk_en_i(sclk_en), .fsync_i(fsync),
    .sdo_o(sdo), .rdy_o(rdy)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic hi, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_hi = hi; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick(logic fs);
    @(negedge clk); sclk_en = 1; fsync = fs;
    @(negedge clk); sclk_en = 0; fsync = 0;
  endtask

  task automatic run_bits(logic first, int n, output logic [63:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      tick(first && i == 0);
      got = {got[62:0], sdo};
    end
  endtask

  function automatic int len_of(logic [2:0] c);
    case (c) 0: return 8; 1: return 12; 2: return 16; 3: return 20; 4: return 24; default: return 32; endcase
  endfunction

  function automatic logic [7:0] ref_mu(logic [15:0] x);
    int v, seg, mask;
    v = $signed(x); v = v >>> 2;
    if (v < 0) begin v = -v; mask = 'h7F; end else mask = 'hFF;
    if (v > 8159) v = 8159;
    v += 33;
    seg = 8;
    for (int i = 7; i >= 0; i--) if (v <= ((64 << i) - 1)) seg = i;
    if (seg == 8) return 8'('h7F ^ mask);
    return 8'(((seg << 4) | ((v >> (seg + 1)) & 15)) ^ mask);
  endfunction

  function automatic logic [7:0] ref_a(logic [15:0] x);
    int v, seg, mask, av;
    v = $signed(x); v = v >>> 3;
    if (v >= 0) mask = 'hD5; else begin mask = 'h55; v = -v - 1; end
    seg = 8;
    for (int i = 7; i >= 0; i--) if (v <= ((32 << i) - 1)) seg = i;
    if (seg == 8) return 8'('h7F ^ mask);
    av = seg << 4;
    av |= (seg < 2) ? ((v >> 1) & 15) : ((v >> seg) & 15);
    return 8'(av ^ mask);
  endfunction

  // single-phase frame, expected word from register values
  task automatic frame_plain(string req, logic [15:0] hi, logic [15:0] lo, logic [2:0] code);
    logic [63:0] got, exp;
    int n;
    n = len_of(code);
    l1 = code; dual = 0; cmode = 2'b00;
    exp = (n > 16) ? {32'b0, hi, lo} : {48'b0, lo};
    exp = exp & ((64'd1 << n) - 1);
    run_bits(1, n, got);
    chk(got == exp, req, got, exp);
    tick(0);
  endtask

  task automatic t_reset;
    logic [63:0] got;
    chk(rdy == 1'b1, "R1 rdy after reset", 64'(rdy), 64'd1);
    chk(sdo == 1'b0, "R1 sdo after reset", 64'(sdo), 64'd0);
    l1 = 3'd5; dual = 0;
    run_bits(1, 32, got);
    chk(got == 64'd0, "R1 zero registers", got, 64'd0);
    tick(0);
  endtask

  task automatic t_lengths;
    wr(0, 16'hA5C3); wr(1, 16'h1234);
    frame_plain("R2 R3 R4 16-bit", 16'h1234, 16'hA5C3, 3'd2);
    frame_plain("R4 8-bit drops upper", 16'h1234, 16'hA5C3, 3'd0);
    frame_plain("R4 12-bit", 16'h1234, 16'hA5C3, 3'd1);
    frame_plain("R5 20-bit", 16'h1234, 16'hA5C3, 3'd3);
    frame_plain("R5 24-bit", 16'h1234, 16'hA5C3, 3'd4);
    frame_plain("R5 32-bit hi first", 16'h1234, 16'hA5C3, 3'd5);
    frame_plain("R4 code 7 is 32-bit", 16'h1234, 16'hA5C3, 3'd7);
    frame_plain("R13 repeat unchanged", 16'h1234, 16'hA5C3, 3'd5);
  endtask

  task automatic t_dual;
    logic [63:0] got;
    wr(1, 16'hBEEF); wr(0, 16'h1281);
    l1 = 3'd0; l2 = 3'd4; dual = 1; cmode = 2'b00;
    run_bits(1, 3, got);
    chk(got == 64'h4, "R6 phase1 head", got, 64'h4);
    chk(rdy == 1'b1, "R12 rdy set on load", 64'(rdy), 64'd1);
    wr(0, 16'h0F0F);
    chk(rdy == 1'b0, "R12 rdy cleared by low write", 64'(rdy), 64'd0);
    run_bits(0, 5, got);
    chk(got == 64'h01, "R6 phase1 keeps old word", got, 64'h01);
    run_bits(0, 24, got);
    chk(got == 64'hEF0F0F, "R6 phase2 reloads", got, 64'hEF0F0F);
    chk(rdy == 1'b1, "R12 rdy set on phase2 load", 64'(rdy), 64'd1);
    wr(1, 16'h5555);
    chk(rdy == 1'b1, "R12 high write keeps rdy", 64'(rdy), 64'd1);
    tick(0);
    chk(sdo == 1'b0, "R7 idle after dual frame", 64'(sdo), 64'd0);
    dual = 0;
  endtask

  task automatic t_end_and_ignore;
    logic [63:0] got;
    wr(0, 16'h0081); l1 = 3'd0; dual = 0;
    run_bits(1, 8, got);
    chk(got == 64'h81, "R7 first frame", got, 64'h81);
    run_bits(1, 8, got);
    chk(got == 64'h81, "R7 back-to-back restart", got, 64'h81);
    tick(0);
    chk(sdo == 1'b0, "R7 low after last bit", 64'(sdo), 64'd0);
    tick(0);
    chk(sdo == 1'b0, "R3 no start without fsync", 64'(sdo), 64'd0);
    wr(0, 16'hF00F); l1 = 3'd2;
    run_bits(1, 6, got);
    chk(got == 64'h3C, "R8 head", got, 64'h3C);
    run_bits(1, 10, got);
    chk(got == 64'h00F, "R8 fsync mid-frame ignored", got, 64'h00F);
    tick(0);
  endtask

  task automatic t_comp(logic [1:0] mode, string req);
    logic [15:0] vec [10] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h0100, 16'hFF00,
                              16'h1234, 16'hEDCB, 16'h0004, 16'hFFFF, 16'h0400};
    logic [63:0] got, exp;
    cmode = mode; l1 = 3'd5; dual = 0;
    foreach (vec[k]) begin
      wr(0, vec[k]);
      exp = 64'(mode[0] ? ref_a(vec[k]) : ref_mu(vec[k]));
      run_bits(1, 8, got);
      chk(got == exp, req, got, exp);
      tick(0);
      chk(sdo == 1'b0, "R9 compressed word is 8 bits", 64'(sdo), 64'd0);
    end
    cmode = 2'b00;
  endtask

  task automatic t_known_codes;
    chk(ref_mu(16'h0000) == 8'hFF && ref_mu(16'h7FFF) == 8'h80 && ref_mu(16'h8000) == 8'h00,
        "R10 reference anchors", 64'(ref_mu(16'h0000)), 64'hFF);
    chk(ref_a(16'h0000) == 8'hD5, "R11 reference anchor", 64'(ref_a(16'h0000)), 64'hD5);
  endtask

  task automatic t_mode01;
    logic [63:0] got;
    wr(0, 16'h8421); cmode = 2'b01; l1 = 3'd2; dual = 0;
    run_bits(1, 16, got);
    chk(got == 64'h8421, "R9 mode 01 uncompressed", got, 64'h8421);
    tick(0);
    cmode = 2'b00;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_dual();
    t_end_and_ignore();
    t_known_codes();
    t_comp(2'b10, "R10 mu-law code");
    t_comp(2'b11, "R11 A-law code");
    t_mode01();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule